// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block is the serial-bus front end of a peripheral. A host on a two-wire (I2C) bus reaches an 8-bit register file through it. Both bus lines are brought into the system clock domain, where the block detects start, repeated-start and stop conditions. It matches its 7-bit device address and acknowledges each byte. It keeps a register pointer and issues single-cycle read and write strobes on a simple register port. The two low bits of the device address come from strap pins, which are sampled after reset.

A write transfer sends the device address with the write bit, then one pointer byte, then any number of data bytes. A read transfer normally loads the pointer in a write phase. A repeated start with the read bit follows, and the block then returns bytes until the host answers with a not-acknowledge. After every byte the pointer moves on by one, except at addresses in a parameter list, such as a FIFO window or a command data port. At those addresses the pointer stays put. The general-call address accepts two commands. One re-samples the strap pins. The other re-samples them and also pulses a soft-reset output to the register file.

Top module: `i2c_regport_slave`

## Requirements
- R1: Before a start condition (SDA falling while SCL is high) the block acknowledges nothing and issues no register access. It never pulls SDA while it is idle.
- R2: The 7-bit device address is 0x42 plus the 2-bit strap value sampled after reset. For straps 00, 01, 10 and 11 the address byte with write bit is 0x84, 0x86, 0x88 and 0x8A. The read bit is the address byte's LSB, set to 1. A matching address byte is acknowledged by pulling SDA low during the ninth clock.
- R3: An address byte that matches neither the device address nor the general call gets no acknowledge. No register access follows it.
- R4: In a write transfer, the first byte after the address loads the pointer. Each later data byte is acknowledged and produces one write strobe at the pointer address.
- R5: Outside the fixed-address list (default: only 0x10), the pointer advances by one after every byte read or written, wrapping at 0xFF.
- R6: While the pointer equals an address in the fixed list, reads and writes leave it unchanged. Repeated accesses all go to that address.
- R7: After a repeated start with the read bit, data goes out MSB first, one bit per SCL period. A read strobe is issued for each byte fetched. Bytes continue while the host acknowledges, and a not-acknowledge ends the transfer.
- R8: A general call (address byte 0x00) is acknowledged. A second byte of 0x06 is acknowledged and pulses `soft_rst_o` for one cycle. It also clears the pointer to 0 and re-samples the strap pins.
- R9: A general-call second byte of 0x04 is acknowledged and re-samples the strap pins. There is no soft-reset pulse and the pointer is kept.
- R10: A general-call second byte of 0x00 gets no acknowledge. Any other second byte is acknowledged and has no effect on the device address, the pointer or `soft_rst_o`.
- R11: A start or stop condition in the middle of a byte abandons that byte. No register access follows, and the block goes back to waiting for an address byte or for a start.
- R12: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 2 | Device address strap pins |
| reg_addr_o | output | 8 | Register pointer |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 8 | Write data, valid with `reg_wr_o` |
| reg_rd_o | output | 1 | One-cycle read strobe; data is taken from `reg_rdata_i` in the same cycle |
| reg_rdata_i | input | 8 | Read data for `reg_addr_o` |
| soft_rst_o | output | 1 | One-cycle soft-reset pulse |

## Verification
A bad pointer shows up within the same byte: the write strobe carries a wrong address, or a later read returns a neighbouring register's contents. A bad latched strap or address match shows up on the ninth clock of the very next address byte, as a missing or stray acknowledge. If the bit counter or the receive state slips, the acknowledge lands on the wrong SCL period, or a data bit is read shifted. Both appear at the host within one byte time. Every transfer ends with a read-back, so a stray write from an aborted byte is caught too.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

   localparam int BYTE_W = 8;

   localparam logic [7:0] GC_ADDR_BYTE = 8'h00;
   localparam logic [7:0] GC_CMD_RESET = 8'h06;
   localparam logic [7:0] GC_CMD_LATCH = 8'h04;
   localparam logic [7:0] GC_CMD_BAD   = 8'h00;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_REG,
      ST_WR,
      ST_RD,
      ST_GC,
      ST_DONE
   } bus_state_t;

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl,
   output logic rise,
   output logic fall
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2cs_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] pipe;
   logic              last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe <= {STAGES{RST_VAL}};
         last <= RST_VAL;
      end else begin
         pipe <= {pipe[STAGES-2:0], din};
         last <= pipe[STAGES-1];
      end
   end

   assign lvl  = pipe[STAGES-1];
   assign rise = lvl & ~last;
   assign fall = ~lvl & last;

endmodule

// File: rtl/i2cs_strap_latch.sv
module i2cs_strap_latch #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] strap_i,
   input  logic         relatch,
   output logic [W-1:0] strap_q
);

   if (W < 1) begin : g_bad_w
      $error("i2cs_strap_latch: W must be positive");
   end

   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strap_q <= '0;
         armed   <= 1'b1;
      end else if (armed || relatch) begin
         strap_q <= strap_i;
         armed   <= 1'b0;
      end
   end

   // strap value only moves on the first cycle after reset or on a re-sample command
   p_strap_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !relatch) |=> $stable(strap_q));

endmodule

// File: rtl/i2cs_reg_ptr.sv
module i2cs_reg_ptr #(
   parameter int                      AW          = 8,
   parameter int                      NUM_FIXED   = 1,
   parameter logic [NUM_FIXED*AW-1:0] FIXED_ADDRS = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          step,
   output logic [AW-1:0] ptr_o
);

   if (NUM_FIXED < 1) begin : g_bad_num
      $error("i2cs_reg_ptr: NUM_FIXED must be at least 1");
   end

   logic [AW-1:0]        ptr_q;
   logic [NUM_FIXED-1:0] hit;
   logic                 is_fixed;

   for (genvar g = 0; g < NUM_FIXED; g++) begin : g_fix
      assign hit[g] = (ptr_q == FIXED_ADDRS[g*AW +: AW]);
   end

   assign is_fixed = |hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (clear) begin
         ptr_q <= '0;
      end else if (load) begin
         ptr_q <= load_val;
      end else if (step && !is_fixed) begin
         ptr_q <= ptr_q + AW'(1);
      end
   end

   assign ptr_o = ptr_q;

   p_step_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && !clear && !is_fixed) |=> (ptr_o == $past(ptr_o) + AW'(1)));

   p_fixed_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && !clear && is_fixed) |=> (ptr_o == $past(ptr_o)));

   p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (ptr_o == '0));

endmodule

// File: rtl/i2c_regport_slave.sv
module i2c_regport_slave
   import i2cs_pkg::*;
#(
   parameter int                      SYNC_STAGES = 2,
   parameter int                      AW          = 8,
   parameter int                      STRAP_W     = 2,
   parameter logic [6:0]              DEV_BASE    = 7'h42,
   parameter int                      NUM_FIXED   = 1,
   parameter logic [NUM_FIXED*AW-1:0] FIXED_ADDRS = 8'h10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               sda_pull_o,
   input  logic [STRAP_W-1:0] strap_i,
   output logic [AW-1:0]      reg_addr_o,
   output logic               reg_wr_o,
   output logic [7:0]         reg_wdata_o,
   output logic               reg_rd_o,
   input  logic [7:0]         reg_rdata_i,
   output logic               soft_rst_o
);

   localparam int              CNT_W    = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

   if (AW < 1 || AW > 8) begin : g_bad_aw
      $error("i2c_regport_slave: AW must be 1..8");
   end
   if (STRAP_W < 1 || STRAP_W > 6) begin : g_bad_strap
      $error("i2c_regport_slave: STRAP_W must be 1..6");
   end
   if (int'(DEV_BASE) + (2 ** STRAP_W) - 1 > 127) begin : g_bad_base
      $error("i2c_regport_slave: DEV_BASE plus strap range overflows 7 bits");
   end

   // bus line conditioning
   logic scl_lvl, scl_rise, scl_fall;
   logic sda_lvl, sda_rise, sda_fall;

   i2cs_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
      .clk (clk), .rst_n (rst_n), .din (scl_i),
      .lvl (scl_lvl), .rise (scl_rise), .fall (scl_fall)
   );

   i2cs_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
      .clk (clk), .rst_n (rst_n), .din (sda_i),
      .lvl (sda_lvl), .rise (sda_rise), .fall (sda_fall)
   );

   // device address
   logic [STRAP_W-1:0] strap_q;
   logic [6:0]         dev7;
   logic               gc_latch;

   i2cs_strap_latch #(.W(STRAP_W)) u_strap (
      .clk (clk), .rst_n (rst_n), .strap_i (strap_i),
      .relatch (gc_latch), .strap_q (strap_q)
   );

   assign dev7 = DEV_BASE + 7'(strap_q);

   // byte engine state
   bus_state_t       state;
   logic [CNT_W-1:0] bitcnt;
   logic             in_ack;
   logic             m_ack;
   logic             pull_q;
   logic [7:0]       rx_q;
   logic [7:0]       tx_q;
   logic [2:0]       tx_idx;
   logic             soft_q;

   logic start_c, stop_c, bus_ev;
   logic byte_end, ack_end;
   logic dev_match, gc_sel;
   logic wr_fire, rd_fire, ptr_load, gc_hit, gc_reset;
   logic [AW-1:0] ptr;

   always_comb begin
      start_c   = sda_fall & scl_lvl & ~scl_rise;
      stop_c    = sda_rise & scl_lvl & ~scl_rise;
      bus_ev    = start_c | stop_c;
      byte_end  = scl_fall & ~in_ack & (bitcnt == LAST_BIT) & ~bus_ev;
      ack_end   = scl_fall & in_ack & ~bus_ev;
      dev_match = (rx_q[7:1] == dev7);
      gc_sel    = (rx_q == GC_ADDR_BYTE);
      wr_fire   = byte_end & (state == ST_WR);
      rd_fire   = ack_end & (state == ST_RD) & m_ack;
      ptr_load  = byte_end & (state == ST_REG);
      gc_hit    = byte_end & (state == ST_GC);
      gc_reset  = gc_hit & (rx_q == GC_CMD_RESET);
      gc_latch  = gc_hit & ((rx_q == GC_CMD_RESET) | (rx_q == GC_CMD_LATCH));
      tx_idx    = 3'(BYTE_W - 1) - bitcnt[2:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         bitcnt <= '0;
         in_ack <= 1'b0;
         m_ack  <= 1'b0;
         pull_q <= 1'b0;
         rx_q   <= '0;
         tx_q   <= '0;
      end else if (start_c) begin
         state  <= ST_DEV;
         bitcnt <= '0;
         in_ack <= 1'b0;
         pull_q <= 1'b0;
      end else if (stop_c) begin
         state  <= ST_IDLE;
         bitcnt <= '0;
         in_ack <= 1'b0;
         pull_q <= 1'b0;
      end else if (state == ST_RD) begin
         if (scl_rise) begin
            if (in_ack) m_ack  <= ~sda_lvl;
            else        bitcnt <= bitcnt + CNT_W'(1);
         end
         if (ack_end) begin
            in_ack <= 1'b0;
            bitcnt <= '0;
            if (m_ack) begin
               tx_q   <= reg_rdata_i;
               pull_q <= ~reg_rdata_i[BYTE_W-1];
            end else begin
               state  <= ST_IDLE;
               pull_q <= 1'b0;
            end
         end else if (scl_fall && !in_ack) begin
            if (bitcnt == LAST_BIT) begin
               pull_q <= 1'b0;
               in_ack <= 1'b1;
            end else begin
               pull_q <= ~tx_q[tx_idx];
            end
         end
      end else if (state != ST_IDLE) begin
         if (scl_rise && !in_ack) begin
            rx_q   <= {rx_q[6:0], sda_lvl};
            bitcnt <= bitcnt + CNT_W'(1);
         end
         if (ack_end) begin
            in_ack <= 1'b0;
            pull_q <= 1'b0;
            bitcnt <= '0;
            if (state == ST_DONE) state <= ST_IDLE;
         end else if (byte_end) begin
            case (state)
               ST_DEV: begin
                  if (dev_match) begin
                     pull_q <= 1'b1;
                     in_ack <= 1'b1;
                     m_ack  <= 1'b1;
                     state  <= rx_q[0] ? ST_RD : ST_REG;
                  end else if (gc_sel) begin
                     pull_q <= 1'b1;
                     in_ack <= 1'b1;
                     state  <= ST_GC;
                  end else begin
                     state  <= ST_IDLE;
                  end
               end
               ST_REG: begin
                  pull_q <= 1'b1;
                  in_ack <= 1'b1;
                  state  <= ST_WR;
               end
               ST_WR: begin
                  pull_q <= 1'b1;
                  in_ack <= 1'b1;
               end
               ST_GC: begin
                  if (rx_q == GC_CMD_BAD) begin
                     state <= ST_IDLE;
                  end else begin
                     pull_q <= 1'b1;
                     in_ack <= 1'b1;
                     state  <= ST_DONE;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) soft_q <= 1'b0;
      else        soft_q <= gc_reset;
   end

   i2cs_reg_ptr #(
      .AW (AW), .NUM_FIXED (NUM_FIXED), .FIXED_ADDRS (FIXED_ADDRS)
   ) u_ptr (
      .clk (clk), .rst_n (rst_n),
      .clear (gc_reset), .load (ptr_load), .load_val (rx_q[AW-1:0]),
      .step (wr_fire | rd_fire), .ptr_o (ptr)
   );

   assign sda_pull_o  = pull_q;
   assign reg_addr_o  = ptr;
   assign reg_wr_o    = wr_fire;
   assign reg_wdata_o = rx_q;
   assign reg_rd_o    = rd_fire;
   assign soft_rst_o  = soft_q;

   p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_pull_o);

   p_mismatch_nack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_end && state == ST_DEV && !dev_match && !gc_sel) |=> !sda_pull_o);

   p_write_acked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_o |=> sda_pull_o);

   p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr_o && reg_rd_o));

   p_soft_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_o |=> !soft_rst_o);

   p_scl_low_drive_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(sda_pull_o) |-> !scl_lvl);

endmodule

// File: tb/i2c_regport_slave_test.sv
module i2c_regport_slave_test;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int         T      = 20;
   localparam logic [7:0] FIFO_A = 8'h10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_bus;
   logic [1:0] strap = 2'b10;
   logic       sda_pull;
   logic [7:0] addr, wdata, rdata;
   logic       reg_wr, reg_rd, soft_rst;

   always #2 clk = ~clk;

   assign sda_bus = sda_m & ~sda_pull;

   i2c_regport_slave uut (
      .clk (clk), .rst_n (rst_n), .scl_i (scl_m), .sda_i (sda_bus),
      .sda_pull_o (sda_pull), .strap_i (strap),
      .reg_addr_o (addr), .reg_wr_o (reg_wr), .reg_wdata_o (wdata),
      .reg_rd_o (reg_rd), .reg_rdata_i (rdata), .soft_rst_o (soft_rst)
   );

   // register file stand-in: plain storage plus a counting FIFO window
   logic [7:0] mem [0:255];
   logic [7:0] fifo_cnt;
   assign rdata = (addr == FIFO_A) ? fifo_cnt : mem[addr];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
         fifo_cnt <= 8'hA0;
      end else begin
         if (reg_wr && addr != FIFO_A) mem[addr] <= wdata;
         if (reg_rd && addr == FIFO_A) fifo_cnt <= fifo_cnt + 8'd1;
      end
   end

   int n_chk = 0;
   int n_err = 0;
   int soft_cnt = 0;
   int viol = 0;
   bit done = 0;
   logic prev_pull = 1'b0;
   logic [15:0] exp_q[$];

   logic [7:0] mdl_mem [0:255];
   logic [7:0] mdl_ptr = 8'h00;
   logic [7:0] mdl_fifo = 8'hA0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor for write strobes
   always @(negedge clk) begin
      if (rst_n && reg_wr) begin
         logic [15:0] e;
         n_chk++;
         if (exp_q.size() == 0) begin
            n_err++;
            $display("FAIL R4 unexpected write: actual=%0h expected=none", {addr, wdata});
         end else begin
            e = exp_q.pop_front();
            if (e != {addr, wdata}) begin
               n_err++;
               $display("FAIL R5 write addr/data: actual=%0h expected=%0h", {addr, wdata}, e);
            end
         end
      end
      if (rst_n && soft_rst) soft_cnt++;
      if (rst_n && sda_pull != prev_pull && scl_m) viol++;   // R12 watch
      prev_pull <= sda_pull;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic i2c_start();
      sda_m = 1'b1; tick(T);
      scl_m = 1'b1; tick(T);
      sda_m = 1'b0; tick(T);
      scl_m = 1'b0; tick(2);
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; tick(T);
      scl_m = 1'b1; tick(T);
      sda_m = 1'b1; tick(T);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; tick(T);
         scl_m = 1'b1; tick(T);
         scl_m = 1'b0; tick(2);
      end
      sda_m = 1'b1; tick(T);
      scl_m = 1'b1; tick(T/2);
      ack = !sda_bus;
      tick(T/2);
      scl_m = 1'b0; tick(2);
   endtask

   task automatic recv_byte(input bit mack, output logic [7:0] d);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tick(T);
         scl_m = 1'b1; tick(T/2);
         d[i] = sda_bus;
         tick(T/2);
         scl_m = 1'b0; tick(2);
      end
      sda_m = mack ? 1'b0 : 1'b1; tick(T);
      scl_m = 1'b1; tick(T);
      scl_m = 1'b0; tick(2);
      sda_m = 1'b1;
   endtask

   task automatic partial(input int bits);
      for (int i = 0; i < bits; i++) begin
         sda_m = 1'b1; tick(T);
         scl_m = 1'b1; tick(T);
         scl_m = 1'b0; tick(2);
      end
   endtask

   task automatic dev_phase(input logic [7:0] b, input bit exp_ack, input string req);
      bit a;
      i2c_start();
      send_byte(b, a);
      check(a == exp_ack, req, a, exp_ack);
   endtask

   task automatic do_write(input logic [7:0] r, input int n, input logic [7:0] base);
      bit a;
      send_byte(r, a);
      check(a == 1'b1, "R4", a, 1);
      mdl_ptr = r;
      for (int i = 0; i < n; i++) begin
         logic [7:0] v;
         v = base + 8'(i);
         exp_q.push_back({mdl_ptr, v});
         if (mdl_ptr != FIFO_A) mdl_mem[mdl_ptr] = v;
         send_byte(v, a);
         check(a == 1'b1, "R4", a, 1);
         if (mdl_ptr != FIFO_A) mdl_ptr = mdl_ptr + 8'd1;
      end
   endtask

   task automatic do_read(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         logic [7:0] e, d;
         if (mdl_ptr == FIFO_A) begin
            e = mdl_fifo;
            mdl_fifo = mdl_fifo + 8'd1;
         end else begin
            e = mdl_mem[mdl_ptr];
            mdl_ptr = mdl_ptr + 8'd1;
         end
         recv_byte(i < n - 1, d);
         check(d == e, req, d, e);
      end
   endtask

   initial begin
      bit a;
      for (int i = 0; i < 256; i++) mdl_mem[i] = 8'h00;
      rst_n = 1'b0;
      tick(10);
      rst_n = 1'b1;
      tick(5);

      // reset state
      check(sda_pull == 1'b0, "R1", sda_pull, 0);
      check(reg_wr == 1'b0 && reg_rd == 1'b0, "R1", {reg_wr, reg_rd}, 0);
      check(soft_rst == 1'b0, "R8", soft_rst, 0);

      // R1: clocked byte with no start is ignored
      scl_m = 1'b0; tick(T);
      send_byte(8'h88, a);
      check(a == 1'b0, "R1", a, 0);
      i2c_stop();

      // R3: foreign addresses
      dev_phase(8'h84, 1'b0, "R3"); i2c_stop();
      dev_phase(8'h8A, 1'b0, "R3"); i2c_stop();

      // R2/R4/R5: incrementing write, strap 10 -> 0x88
      dev_phase(8'h88, 1'b1, "R2");
      do_write(8'h20, 3, 8'h11);
      i2c_stop();

      // R6: write running into the fixed address
      dev_phase(8'h88, 1'b1, "R6");
      do_write(8'h0F, 3, 8'h50);
      i2c_stop();

      // R7: read back through a repeated start
      dev_phase(8'h88, 1'b1, "R7");
      do_write(8'h20, 0, 8'h00);
      dev_phase(8'h89, 1'b1, "R7");
      do_read(3, "R7");
      i2c_stop();

      // R6: reads from the fixed address stay there
      dev_phase(8'h88, 1'b1, "R6");
      do_write(FIFO_A, 0, 8'h00);
      dev_phase(8'h89, 1'b1, "R6");
      do_read(3, "R6");
      i2c_stop();

      // R8: general-call reset with new strap
      dev_phase(8'h88, 1'b1, "R4");
      do_write(8'h00, 1, 8'h5A);
      i2c_stop();
      strap = 2'b01;
      dev_phase(8'h00, 1'b1, "R8");
      send_byte(8'h06, a);
      check(a == 1'b1, "R8", a, 1);
      i2c_stop();
      check(soft_cnt == 1, "R8", soft_cnt, 1);
      mdl_ptr = 8'h00;
      dev_phase(8'h88, 1'b0, "R8"); i2c_stop();
      dev_phase(8'h87, 1'b1, "R8");
      do_read(1, "R8");
      i2c_stop();

      // R9: re-latch only, pointer kept
      dev_phase(8'h86, 1'b1, "R9");
      do_write(8'h20, 0, 8'h00);
      i2c_stop();
      strap = 2'b11;
      dev_phase(8'h00, 1'b1, "R9");
      send_byte(8'h04, a);
      check(a == 1'b1, "R9", a, 1);
      i2c_stop();
      check(soft_cnt == 1, "R9", soft_cnt, 1);
      dev_phase(8'h8B, 1'b1, "R9");
      do_read(1, "R9");
      i2c_stop();

      // R10: forbidden and ignored second bytes
      dev_phase(8'h00, 1'b1, "R10");
      send_byte(8'h00, a);
      check(a == 1'b0, "R10", a, 0);
      i2c_stop();
      strap = 2'b00;
      dev_phase(8'h00, 1'b1, "R10");
      send_byte(8'h37, a);
      check(a == 1'b1, "R10", a, 1);
      i2c_stop();
      check(soft_cnt == 1, "R10", soft_cnt, 1);
      dev_phase(8'h8B, 1'b1, "R10");
      do_read(1, "R10");
      i2c_stop();

      // R11: stop in mid byte, then start in mid byte
      dev_phase(8'h8A, 1'b1, "R11");
      do_write(8'h40, 0, 8'h00);
      partial(4);
      i2c_stop();
      dev_phase(8'h8A, 1'b1, "R11");
      do_write(8'h41, 0, 8'h00);
      partial(3);
      i2c_start();
      send_byte(8'h8B, a);
      check(a == 1'b1, "R11", a, 1);
      do_read(1, "R11");
      i2c_stop();
      dev_phase(8'h8A, 1'b1, "R11");
      do_write(8'h40, 0, 8'h00);
      dev_phase(8'h8B, 1'b1, "R11");
      do_read(1, "R11");
      i2c_stop();

      tick(20);
      check(exp_q.size() == 0, "R4", exp_q.size(), 0);
      check(viol == 0, "R12", viol, 0);

      if (!done) begin
         done = 1;
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule